// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block sits beside a processor and watches the path the program takes through its basic blocks. Before each block starts, the processor reports that block's node number on a valid/ready report port. The watchdog checks the report against a small programmable table that lists each node's allowed successors, and raises a sticky sequence error when the path leaves the allowed graph.

While a node is running, the watchdog watches the instruction bus. It folds every fetched opcode into a running XOR. When the processor pulses the exit strobe at the end of the node, the watchdog compares that running value with the checksum programmed for the node. A mismatch raises a sticky checksum error. Each check has its own enable, so either can run alone or both together. A single clear input drops both flags.

The table is written through a plain write port, one node per cycle. Each node record holds an entry-point bit, two successor slots (each with a valid bit) and the expected checksum. A node with both successor slots invalid is terminal. The report port applies back-pressure only while the table is being written: `rep_ready` is low in any cycle with `cfg_we` high, and a report is taken only in a cycle where `rep_valid` and `rep_ready` are both high. The opcode snoop port cannot stall the bus, so it has a valid strobe and no ready.

Top module: `cf_watchdog`

## Requirements
- R1: After reset both error flags are low, no node is active, every table record is cleared (no entry bits, no valid successors, checksum zero), and `rep_ready` is high.
- R2: A report taken as the first report after reset, or taken while the current node is terminal (both successor valid bits clear), is legal only if the reported node's entry bit is set.
- R3: Any other taken report is legal only if it equals a successor slot of the current node whose valid bit is set. An illegal report sets `seq_err` on the next clock edge when `chk_seq_en` is high. Cycles with no taken report never set `seq_err`.
- R4: A taken report makes the reported node current and active, and restarts its checksum. The restart value is the opcode snooped in that same cycle, or zero if no opcode is snooped. While a node is active, each snooped opcode is XORed into the running checksum.
- R5: An exit strobe while a node is active ends the node and compares its final XOR with the node's programmed checksum. The final XOR includes an opcode snooped in the same cycle, unless a report is also taken in that cycle, in which case the opcode belongs to the new node. A mismatch sets `sum_err` when `chk_sum_en` is high.
- R6: While no node is active, snooped opcodes and exit strobes have no effect on the checksum or on `sum_err`.
- R7: With `chk_seq_en` low no report sets `seq_err`, and with `chk_sum_en` low no exit sets `sum_err`. The two enables act independently.
- R8: Both flags stay high until `err_clr` is asserted and clear on the next edge. If an error is detected in the same cycle as `err_clr`, the flag ends up set.
- R9: `rep_ready` is low in every cycle where `cfg_we` is high, and a report offered in such a cycle is not taken.
- R10: A table write with `cfg_we` high stores the record for `cfg_node`. Checks use the new record from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_node | input | NODE_W | Node whose record is written |
| cfg_entry | input | 1 | Node may start a path |
| cfg_nxt0 | input | NODE_W | First successor |
| cfg_nxt0_ok | input | 1 | First successor slot valid |
| cfg_nxt1 | input | NODE_W | Second successor |
| cfg_nxt1_ok | input | 1 | Second successor slot valid |
| cfg_sum | input | OP_W | Expected opcode XOR for the node |
| rep_valid | input | 1 | Node report offered |
| rep_ready | output | 1 | Report can be taken |
| rep_node | input | NODE_W | Reported node number |
| ins_valid | input | 1 | Opcode fetch seen on the bus |
| ins_opcode | input | OP_W | Snooped opcode |
| exit_stb | input | 1 | Current node ends |
| chk_seq_en | input | 1 | Enable transition checking |
| chk_sum_en | input | 1 | Enable checksum checking |
| err_clr | input | 1 | Clear both error flags |
| seq_err | output | 1 | Sticky illegal-transition flag |
| sum_err | output | 1 | Sticky checksum-mismatch flag |

## Verification
The bench targets the cases where legality changes source. These are the first report after reset and the report after a terminal node, where a design that ignored the entry bits would accept a non-entry start or reject a legal loop back to an entry node. It also drives opcodes in the same cycle as a report or an exit. A design that gave such an opcode to the wrong node would raise false checksum errors on clean paths. Opcodes and exits with no active node, errors coinciding with a clear, and reports offered during a table write are exercised as well; mishandling them shows up as a phantom error, a lost error or a report taken while `rep_ready` is low. Long random runs then mix all of these against a reference model.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int DEF_NODE_W = 3;
  localparam int DEF_OP_W   = 8;

  typedef enum logic {
    SRC_ENTRY = 1'b0,
    SRC_SUCC  = 1'b1
  } legal_src_e;
endpackage

// File: rtl/cfw_table.sv
module cfw_table #(
  parameter int NODE_W = 3,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NODE_W-1:0] wr_node,
  input  logic              wr_entry,
  input  logic [NODE_W-1:0] wr_nxt0,
  input  logic              wr_nxt0_ok,
  input  logic [NODE_W-1:0] wr_nxt1,
  input  logic              wr_nxt1_ok,
  input  logic [OP_W-1:0]   wr_sum,
  input  logic [NODE_W-1:0] cur_idx,
  output logic [NODE_W-1:0] cur_nxt0,
  output logic              cur_nxt0_ok,
  output logic [NODE_W-1:0] cur_nxt1,
  output logic              cur_nxt1_ok,
  output logic [OP_W-1:0]   cur_sum,
  input  logic [NODE_W-1:0] new_idx,
  output logic              new_entry
);
  localparam int NODES = 1 << NODE_W;

  logic              entry_q [NODES];
  logic [NODE_W-1:0] nxt0_q  [NODES];
  logic              ok0_q   [NODES];
  logic [NODE_W-1:0] nxt1_q  [NODES];
  logic              ok1_q   [NODES];
  logic [OP_W-1:0]   sum_q   [NODES];

  for (genvar g = 0; g < NODES; g++) begin : g_rec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q[g] <= 1'b0;
        nxt0_q[g]  <= '0;
        ok0_q[g]   <= 1'b0;
        nxt1_q[g]  <= '0;
        ok1_q[g]   <= 1'b0;
        sum_q[g]   <= '0;
      end else if (wr_en && (wr_node == NODE_W'(g))) begin
        entry_q[g] <= wr_entry;
        nxt0_q[g]  <= wr_nxt0;
        ok0_q[g]   <= wr_nxt0_ok;
        nxt1_q[g]  <= wr_nxt1;
        ok1_q[g]   <= wr_nxt1_ok;
        sum_q[g]   <= wr_sum;
      end
    end
  end

  always_comb begin
    cur_nxt0    = nxt0_q[cur_idx];
    cur_nxt0_ok = ok0_q[cur_idx];
    cur_nxt1    = nxt1_q[cur_idx];
    cur_nxt1_ok = ok1_q[cur_idx];
    cur_sum     = sum_q[cur_idx];
    new_entry   = entry_q[new_idx];
  end
endmodule

// File: rtl/cfw_seq_check.sv
module cfw_seq_check
  import cfw_pkg::*;
#(
  parameter int NODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [NODE_W-1:0] node,
  input  logic              node_is_entry,
  input  logic [NODE_W-1:0] nxt0,
  input  logic              nxt0_ok,
  input  logic [NODE_W-1:0] nxt1,
  input  logic              nxt1_ok,
  input  logic              enable,
  input  logic              clear,
  output logic [NODE_W-1:0] cur_node,
  output logic              err
);
  logic       started_q;
  logic       err_q;
  logic       terminal;
  logic       legal;
  logic       raise;
  legal_src_e src;

  always_comb begin
    terminal = !nxt0_ok && !nxt1_ok;
    src      = (!started_q || terminal) ? SRC_ENTRY : SRC_SUCC;
    if (src == SRC_ENTRY) legal = node_is_entry;
    else                  legal = (nxt0_ok && node == nxt0) || (nxt1_ok && node == nxt1);
    raise    = take && enable && !legal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cur_node  <= '0;
      err_q     <= 1'b0;
    end else begin
      if (take) begin
        started_q <= 1'b1;
        cur_node  <= node;
      end
      err_q <= (err_q && !clear) || raise;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/cfw_sum_check.sv
module cfw_sum_check #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            op_valid,
  input  logic [OP_W-1:0] opcode,
  input  logic            leave,
  input  logic [OP_W-1:0] expect_sum,
  input  logic            enable,
  input  logic            clear,
  output logic            active,
  output logic            err
);
  logic [OP_W-1:0] acc_q;
  logic [OP_W-1:0] op_in;
  logic [OP_W-1:0] final_sum;
  logic            active_q;
  logic            err_q;
  logic            raise;

  always_comb begin
    op_in     = op_valid ? opcode : '0;
    final_sum = take ? acc_q : (acc_q ^ op_in);
    raise     = leave && active_q && enable && (final_sum != expect_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (take)          acc_q <= op_in;
      else if (active_q) acc_q <= acc_q ^ op_in;

      if (take)       active_q <= 1'b1;
      else if (leave) active_q <= 1'b0;

      err_q <= (err_q && !clear) || raise;
    end
  end

  assign active = active_q;
  assign err    = err_q;
endmodule

// File: rtl/cf_watchdog.sv
module cf_watchdog #(
  parameter int NODE_W = cfw_pkg::DEF_NODE_W,
  parameter int OP_W   = cfw_pkg::DEF_OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic              cfg_entry,
  input  logic [NODE_W-1:0] cfg_nxt0,
  input  logic              cfg_nxt0_ok,
  input  logic [NODE_W-1:0] cfg_nxt1,
  input  logic              cfg_nxt1_ok,
  input  logic [OP_W-1:0]   cfg_sum,
  input  logic              rep_valid,
  output logic              rep_ready,
  input  logic [NODE_W-1:0] rep_node,
  input  logic              ins_valid,
  input  logic [OP_W-1:0]   ins_opcode,
  input  logic              exit_stb,
  input  logic              chk_seq_en,
  input  logic              chk_sum_en,
  input  logic              err_clr,
  output logic              seq_err,
  output logic              sum_err
);
  logic              take;
  logic [NODE_W-1:0] cur_node;
  logic [NODE_W-1:0] nxt0;
  logic              nxt0_ok;
  logic [NODE_W-1:0] nxt1;
  logic              nxt1_ok;
  logic [OP_W-1:0]   exp_sum;
  logic              new_entry;
  logic              node_active;

  assign rep_ready = !cfg_we;
  assign take      = rep_valid && rep_ready;

  cfw_table #(.NODE_W(NODE_W), .OP_W(OP_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_we),
    .wr_node     (cfg_node),
    .wr_entry    (cfg_entry),
    .wr_nxt0     (cfg_nxt0),
    .wr_nxt0_ok  (cfg_nxt0_ok),
    .wr_nxt1     (cfg_nxt1),
    .wr_nxt1_ok  (cfg_nxt1_ok),
    .wr_sum      (cfg_sum),
    .cur_idx     (cur_node),
    .cur_nxt0    (nxt0),
    .cur_nxt0_ok (nxt0_ok),
    .cur_nxt1    (nxt1),
    .cur_nxt1_ok (nxt1_ok),
    .cur_sum     (exp_sum),
    .new_idx     (rep_node),
    .new_entry   (new_entry)
  );

  cfw_seq_check #(.NODE_W(NODE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .node          (rep_node),
    .node_is_entry (new_entry),
    .nxt0          (nxt0),
    .nxt0_ok       (nxt0_ok),
    .nxt1          (nxt1),
    .nxt1_ok       (nxt1_ok),
    .enable        (chk_seq_en),
    .clear         (err_clr),
    .cur_node      (cur_node),
    .err           (seq_err)
  );

  cfw_sum_check #(.OP_W(OP_W)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .op_valid   (ins_valid),
    .opcode     (ins_opcode),
    .leave      (exit_stb),
    .expect_sum (exp_sum),
    .enable     (chk_sum_en),
    .clear      (err_clr),
    .active     (node_active),
    .err        (sum_err)
  );
endmodule

// File: rtl/cfw_watchdog_sva.sv
module cfw_watchdog_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic rep_valid,
  input logic rep_ready,
  input logic exit_stb,
  input logic chk_seq_en,
  input logic chk_sum_en,
  input logic err_clr,
  input logic node_active,
  input logic seq_err,
  input logic sum_err
);
  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !rep_ready);

  assert_seq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !err_clr |=> seq_err);

  assert_sum_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_err && !err_clr |=> sum_err);

  assert_seq_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !(rep_valid && rep_ready) |=> !seq_err);

  assert_sum_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !exit_stb |=> !sum_err);

  assert_seq_only_on_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_err && !(rep_valid && rep_ready) |=> !seq_err);

  assert_seq_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_err && !chk_seq_en |=> !seq_err);

  assert_sum_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_err && !chk_sum_en |=> !sum_err);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_err && !node_active |=> !sum_err);

  assert_report_activates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && rep_ready |=> node_active);
endmodule

bind cf_watchdog cfw_watchdog_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .rep_valid   (rep_valid),
  .rep_ready   (rep_ready),
  .exit_stb    (exit_stb),
  .chk_seq_en  (chk_seq_en),
  .chk_sum_en  (chk_sum_en),
  .err_clr     (err_clr),
  .node_active (node_active),
  .seq_err     (seq_err),
  .sum_err     (sum_err)
);

// File: tb/cf_watchdog_bench.sv
module cf_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;
  localparam int OW = 8;
  localparam int NN = 1 << NW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_entry = 0, cfg_nxt0_ok = 0, cfg_nxt1_ok = 0;
  logic [NW-1:0] cfg_node = '0, cfg_nxt0 = '0, cfg_nxt1 = '0, rep_node = '0;
  logic [OW-1:0] cfg_sum = '0, ins_opcode = '0;
  logic rep_valid = 0, ins_valid = 0, exit_stb = 0, err_clr = 0;
  logic chk_seq_en = 1, chk_sum_en = 1;
  logic rep_ready, seq_err, sum_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit            m_entry [NN];
  bit [NW-1:0]   m_n0 [NN];
  bit            m_o0 [NN];
  bit [NW-1:0]   m_n1 [NN];
  bit            m_o1 [NN];
  bit [OW-1:0]   m_sum [NN];
  bit            m_started, m_active, m_seq, m_serr;
  bit [NW-1:0]   m_cur;
  bit [OW-1:0]   m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_watchdog u_cf_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
    .cfg_entry(cfg_entry), .cfg_nxt0(cfg_nxt0), .cfg_nxt0_ok(cfg_nxt0_ok),
    .cfg_nxt1(cfg_nxt1), .cfg_nxt1_ok(cfg_nxt1_ok), .cfg_sum(cfg_sum),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_node(rep_node),
    .ins_valid(ins_valid), .ins_opcode(ins_opcode), .exit_stb(exit_stb),
    .chk_seq_en(chk_seq_en), .chk_sum_en(chk_sum_en), .err_clr(err_clr),
    .seq_err(seq_err), .sum_err(sum_err)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NN; i++) begin
      m_entry[i] = 0; m_n0[i] = '0; m_o0[i] = 0; m_n1[i] = '0; m_o1[i] = 0; m_sum[i] = '0;
    end
    m_started = 0; m_active = 0; m_seq = 0; m_serr = 0; m_cur = '0; m_acc = '0;
  endfunction

  // expected behaviour per R2..R10, evaluated on the inputs present at the edge
  function automatic void model_step();
    bit take, term, legal, sset, uset;
    bit [OW-1:0] op, fin;
    take  = rep_valid && !cfg_we;
    term  = !m_o0[m_cur] && !m_o1[m_cur];
    if (!m_started || term) legal = m_entry[rep_node];
    else legal = (m_o0[m_cur] && rep_node == m_n0[m_cur]) || (m_o1[m_cur] && rep_node == m_n1[m_cur]);
    sset  = take && chk_seq_en && !legal;
    op    = ins_valid ? ins_opcode : '0;
    fin   = take ? m_acc : (m_acc ^ op);
    uset  = exit_stb && m_active && chk_sum_en && (fin != m_sum[m_cur]);
    m_seq  = (m_seq && !err_clr) || sset;
    m_serr = (m_serr && !err_clr) || uset;
    if (take) m_acc = op; else if (m_active) m_acc = m_acc ^ op;
    if (take) m_active = 1; else if (exit_stb) m_active = 0;
    if (take) begin m_started = 1; m_cur = rep_node; end
    if (cfg_we) begin
      m_entry[cfg_node] = cfg_entry; m_n0[cfg_node] = cfg_nxt0; m_o0[cfg_node] = cfg_nxt0_ok;
      m_n1[cfg_node] = cfg_nxt1; m_o1[cfg_node] = cfg_nxt1_ok; m_sum[cfg_node] = cfg_sum;
    end
  endfunction

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    check("R3/R5/R8 model seq_err", seq_err, m_seq);
    check("R3/R5/R8 model sum_err", sum_err, m_serr);
  endtask

  task automatic quiet();
    rep_valid = 0; ins_valid = 0; exit_stb = 0; err_clr = 0; cfg_we = 0;
  endtask

  task automatic do_reset();
    quiet(); rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic write_rec(int n, bit en, int a, bit ao, int b, bit bo, int s);
    cfg_we = 1; cfg_node = NW'(n); cfg_entry = en;
    cfg_nxt0 = NW'(a); cfg_nxt0_ok = ao; cfg_nxt1 = NW'(b); cfg_nxt1_ok = bo; cfg_sum = OW'(s);
    tick(); cfg_we = 0;
  endtask

  // graph: 1 -> {2,3}; 2 -> 4; 3 -> 4; 4 terminal; entry point is node 1
  task automatic program_graph();
    write_rec(1, 1, 2, 1, 3, 1, 'h26);
    write_rec(2, 0, 4, 1, 0, 0, 'hA5);
    write_rec(3, 0, 4, 1, 0, 0, 'hFE);
    write_rec(4, 0, 0, 0, 0, 0, 'h55);
  endtask

  function automatic int op_count(int n);
    case (n) 1: return 2; 3: return 3; default: return 1; endcase
  endfunction

  function automatic logic [OW-1:0] op_of(int n, int i);
    case (n)
      1: return (i == 0) ? 8'h12 : 8'h34;
      2: return 8'hA5;
      3: return (i == 0) ? 8'h0F : ((i == 1) ? 8'hF0 : 8'h01);
      default: return 8'h55;
    endcase
  endfunction

  task automatic run_node(int n, bit bad);
    rep_valid = 1; rep_node = NW'(n); tick(); rep_valid = 0;
    for (int i = 0; i < op_count(n); i++) begin
      ins_valid = 1; ins_opcode = op_of(n, i) ^ ((bad && i == 0) ? 8'h01 : 8'h00); tick();
    end
    ins_valid = 0;
    exit_stb = 1; tick(); exit_stb = 0;
  endtask

  task automatic pulse_clear();
    err_clr = 1; tick(); err_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    check("R1 seq_err after reset", seq_err, 1'b0);
    check("R1 sum_err after reset", sum_err, 1'b0);
    check("R1 rep_ready after reset", rep_ready, 1'b1);

    // R2: empty table after reset, node 1 not yet an entry point
    run_node(1, 0);
    check("R2 non-entry first report flagged", seq_err, 1'b1);
    check("R1 cleared checksum record matches nothing", sum_err, 1'b1);
    pulse_clear();
    check("R8 clear drops seq_err", seq_err, 1'b0);
    check("R8 clear drops sum_err", sum_err, 1'b0);

    do_reset();
    cfg_we = 1; #1;
    check("R9 rep_ready low during write", rep_ready, 1'b0);
    cfg_we = 0;
    program_graph();

    // R2, R10: first report after reset is not an entry point
    run_node(2, 0);
    check("R2 non-entry start flagged", seq_err, 1'b1);
    pulse_clear();

    do_reset(); program_graph();
    run_node(1, 0); run_node(2, 0); run_node(4, 0);
    check("R3 legal path 1-2-4 seq", seq_err, 1'b0);
    check("R5 legal path 1-2-4 sums", sum_err, 1'b0);
    run_node(1, 0); run_node(3, 0); run_node(4, 0);
    check("R2 terminal back to entry legal", seq_err, 1'b0);
    check("R10 programmed checksums match", sum_err, 1'b0);

    run_node(1, 0); run_node(2, 0); run_node(3, 0);
    check("R3 illegal 2->3 flagged", seq_err, 1'b1);
    repeat (3) tick();
    check("R8 seq_err sticky", seq_err, 1'b1);
    pulse_clear();
    check("R8 seq_err cleared", seq_err, 1'b0);
    run_node(4, 0);

    run_node(1, 1);
    check("R5 corrupted opcode flagged", sum_err, 1'b1);
    repeat (2) tick();
    check("R8 sum_err sticky", sum_err, 1'b1);
    pulse_clear();
    check("R8 sum_err cleared", sum_err, 1'b0);

    // R4: opcode in the report cycle belongs to the new node
    rep_valid = 1; rep_node = 3'd2; ins_valid = 1; ins_opcode = 8'hA5; tick();
    rep_valid = 0; ins_valid = 0;
    exit_stb = 1; tick(); exit_stb = 0;
    check("R4 report-cycle opcode counted", sum_err, 1'b0);
    // R5: opcode in the exit cycle counts toward the ending node
    rep_valid = 1; rep_node = 3'd4; tick(); rep_valid = 0;
    exit_stb = 1; ins_valid = 1; ins_opcode = 8'h55; tick();
    exit_stb = 0; ins_valid = 0;
    check("R5 exit-cycle opcode counted", sum_err, 1'b0);

    // R6: idle opcodes and exits do nothing
    ins_valid = 1; ins_opcode = 8'hFF; tick(); tick();
    exit_stb = 1; tick(); exit_stb = 0; ins_valid = 0;
    check("R6 idle exit no error", sum_err, 1'b0);
    run_node(1, 0);
    check("R6 idle opcodes not carried", sum_err, 1'b0);

    // R7: independent enables
    chk_seq_en = 0;
    run_node(4, 0);
    check("R7 seq check off", seq_err, 1'b0);
    chk_seq_en = 1; chk_sum_en = 0;
    run_node(1, 1);
    check("R7 sum check off", sum_err, 1'b0);
    check("R7 seq check still on (4->1 legal)", seq_err, 1'b0);
    chk_sum_en = 1;

    // R8: error in clear cycle wins
    err_clr = 1; rep_valid = 1; rep_node = 3'd4; tick(); err_clr = 0; rep_valid = 0;
    check("R8 set beats clear", seq_err, 1'b1);
    pulse_clear();

    // R9: report offered during a write is not taken
    cfg_we = 1; cfg_node = 3'd7; cfg_entry = 0; cfg_nxt0_ok = 0; cfg_nxt1_ok = 0; cfg_sum = 8'h00;
    rep_valid = 1; rep_node = 3'd6; tick(); cfg_we = 0; rep_valid = 0;
    check("R9 report blocked during write", seq_err, 1'b0);

    // random mix checked against the model each cycle
    for (int it = 0; it < 4000; it++) begin
      bit [NW-1:0] pick;
      pick = NW'($urandom_range(0, NN - 1));
      rep_valid  = ($urandom_range(0, 99) < 15);
      rep_node   = ($urandom_range(0, 9) < 7) ? NW'($urandom_range(1, 4)) : pick;
      ins_valid  = ($urandom_range(0, 1) == 1);
      ins_opcode = ($urandom_range(0, 3) == 0) ? OW'($urandom()) : op_of(int'(m_cur), $urandom_range(0, 2));
      exit_stb   = ($urandom_range(0, 99) < 15);
      err_clr    = ($urandom_range(0, 99) < 5);
      chk_seq_en = ($urandom_range(0, 9) != 0);
      chk_sum_en = ($urandom_range(0, 9) != 0);
      cfg_we     = ($urandom_range(0, 99) < 3);
      cfg_node   = pick; cfg_entry = ($urandom_range(0, 1) == 1);
      cfg_nxt0   = NW'($urandom()); cfg_nxt0_ok = ($urandom_range(0, 1) == 1);
      cfg_nxt1   = NW'($urandom()); cfg_nxt1_ok = ($urandom_range(0, 1) == 1);
      cfg_sum    = OW'($urandom());
      tick();
    end
    quiet();
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule